// File: doc/BRIEF.md
# Averaging Input Frequency Meter

This block measures a square wave that arrives with no clock of its own, typically in the 1 to 4 MHz range with slow drift of a few percent. It runs on a much faster local clock. The input first passes through a two-stage synchroniser. Its rising edges are then detected in the local domain. The block counts local clock cycles across a span of 2^nSel complete input periods, taken as one window. It does not time single periods and add them.

Each window's total is presented as a raw count. The same total also drives a first-order low-pass filter, which gives a smoothed count. The quantisation error of a window stays near one count whatever its length, so longer windows give finer relative resolution. The filter then removes the remaining jitter from one result to the next.

Windows follow one another without a gap: the rising edge that closes a window also opens the next one. If the input stops, the block abandons the open window and raises a no-signal flag. Measurement starts again from the next rising edge.

Top module: `freqMeter`

## Requirements
- R1: After reset, rawCount and filtCount are zero and valid and noSignal are low.
- R2: With a steady input period of P clocks and nSel = s, every full window reports rawCount = 2^s * P.
- R3: The edge that closes a window also opens the next one, so no input period is lost. With periods alternating P and P+1, a window of two periods reads 2P+1, and two successive one-period windows add up to 2P+1.
- R4: nSel is sampled only at a window boundary. A change made in the middle of a window leaves that window at its old length, and the new length applies from the next window.
- R5: The first result after reset, or after a no-signal event, loads filtCount with the raw value. Every later result updates it as y = y + ((x - y) >>> FILT_SHIFT), using a signed arithmetic shift.
- R6: After 2^TIMEOUT_W consecutive clock cycles with no rising edge (including just after reset), noSignal goes high and the open window is dropped with no result. The next rising edge clears noSignal and opens a fresh window.
- R7: valid is a single-cycle pulse. rawCount and filtCount change only in the cycle in which valid is high.
- R8: Only rising edges matter. The reported count does not depend on the duty cycle of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local measuring clock |
| rst | input | 1 | Asynchronous active-high reset |
| sigIn | input | 1 | Asynchronous square wave under measurement |
| nSel | input | NSEL_W | log2 of the number of input periods per window |
| rawCount | output | CNT_W | Clock cycles counted in the last window |
| filtCount | output | CNT_W | Low-pass filtered window count |
| valid | output | 1 | One-cycle strobe marking a new result |
| noSignal | output | 1 | High while the input has stalled |

## Verification
The hardest situation to reach from the ports is a change of window length or a loss of signal that lands in the middle of a window. To reach it, the stimulus waits for a result strobe, counts a fixed number of clocks into the next window, and only then changes nSel or stops the generator. The following results then show whether the open window kept its length or was dropped. An alternating-period generator is used to show that the boundary edge is shared between windows. The exact sum it produces could not come out if any period were skipped or counted twice.

// File: rtl/fm_pkg.sv
package fm_pkg;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic startWin;   // first edge after idle: open a window
    logic closeWin;   // closing edge: publish result and reopen
    logic abort;      // input stalled: drop window, re-prime filter
  } fmStrobe_t;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_MEAS = 1'b1
  } fmState_t;

endpackage

// File: rtl/fmControl.sv
module fmControl
  import fm_pkg::*;
#(
  parameter int TIMEOUT_W = 20,
  parameter int NSEL_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sigIn,
  input  logic [NSEL_W-1:0] nSel,
  output fmStrobe_t         strb,
  output logic              noSignal
);

  localparam int PER_W = (1 << NSEL_W) - 1;

  logic [1:0]           syncQ;
  logic                 lastQ;
  logic                 rise;
  logic [TIMEOUT_W-1:0] idleCnt;
  logic                 timeoutHit;
  logic [PER_W-1:0]     perCnt;
  logic [PER_W-1:0]     lastIdx;
  logic [NSEL_W-1:0]    nLatched;
  fmState_t             state;

  // two-flop synchroniser followed by a rising-edge detector
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], sigIn};
      lastQ <= syncQ[1];
    end
  end

  assign rise       = syncQ[1] & ~lastQ;
  assign timeoutHit = (idleCnt == '1) && !rise;
  assign lastIdx    = PER_W'((32'd1 << nLatched) - 32'd1);

  always_comb begin
    strb          = '0;
    strb.startWin = rise && (state == ST_WAIT);
    strb.closeWin = rise && (state == ST_MEAS) && (perCnt == lastIdx);
    strb.abort    = timeoutHit && !noSignal;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      idleCnt  <= '0;
      noSignal <= 1'b0;
      state    <= ST_WAIT;
      perCnt   <= '0;
      nLatched <= '0;
    end else begin
      if (rise)               idleCnt <= '0;
      else if (idleCnt != '1) idleCnt <= idleCnt + TIMEOUT_W'(1);

      if (rise)            noSignal <= 1'b0;
      else if (timeoutHit) noSignal <= 1'b1;

      if (strb.abort)         state <= ST_WAIT;
      else if (strb.startWin) state <= ST_MEAS;

      if (strb.startWin || strb.closeWin) begin
        perCnt   <= '0;
        nLatched <= nSel;
      end else if (rise && state == ST_MEAS) begin
        perCnt <= perCnt + PER_W'(1);
      end
    end
  end

  // R4
  // period_range_chk: the period counter never runs past the latched window length
  period_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEAS) |-> (perCnt <= lastIdx));

  // R6
  // abort_state_chk: after an abort the block waits and flags no signal
  abort_state_chk: assert property (@(posedge clk) disable iff (rst)
    strb.abort |=> (state == ST_WAIT && noSignal));

endmodule

// File: rtl/fmDatapath.sv
module fmDatapath
  import fm_pkg::*;
#(
  parameter int CNT_W      = 28,
  parameter int FILT_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  fmStrobe_t        strb,
  output logic [CNT_W-1:0] rawCount,
  output logic [CNT_W-1:0] filtCount,
  output logic             valid
);

  localparam int SW = CNT_W + 2;

  logic [CNT_W-1:0]     cycCnt;
  logic                 primed;
  logic signed [SW-1:0] yS, xS, diffS, stepS, yNext;
  logic signed [SW-1:0] loS, hiS;

  assign xS    = SW'(cycCnt);
  assign diffS = xS - yS;
  assign stepS = diffS >>> FILT_SHIFT;
  assign yNext = yS + stepS;
  assign loS   = (xS < yS) ? xS : yS;
  assign hiS   = (xS < yS) ? yS : xS;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cycCnt   <= '0;
      rawCount <= '0;
      valid    <= 1'b0;
      primed   <= 1'b0;
      yS       <= '0;
    end else begin
      valid <= strb.closeWin;

      if (strb.startWin || strb.closeWin) cycCnt <= CNT_W'(1);
      else if (cycCnt != '1)              cycCnt <= cycCnt + CNT_W'(1);

      if (strb.closeWin) begin
        rawCount <= cycCnt;
        yS       <= primed ? yNext : xS;
        primed   <= 1'b1;
      end else if (strb.abort) begin
        primed <= 1'b0;
      end
    end
  end

  assign filtCount = yS[CNT_W-1:0];

  // R2
  // no_overflow_chk: a window never closes on a saturated counter
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    strb.closeWin |-> (cycCnt != '1));

  // R7
  // valid_single_chk: result strobe lasts one cycle
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R7
  // raw_stable_chk: results move only with the strobe
  raw_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(rawCount) && $stable(filtCount)));

  // R5
  // filt_range_chk: a filter step lands between the old value and the new sample
  filt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.closeWin && primed) |=> (yS >= $past(loS) && yS <= $past(hiS)));

endmodule

// File: rtl/freqMeter.sv
module freqMeter
  import fm_pkg::*;
#(
  parameter int TIMEOUT_W  = 20,
  parameter int NSEL_W     = 3,
  parameter int FILT_SHIFT = 3,
  localparam int CNT_W     = TIMEOUT_W + (1 << NSEL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sigIn,
  input  logic [NSEL_W-1:0] nSel,
  output logic [CNT_W-1:0]  rawCount,
  output logic [CNT_W-1:0]  filtCount,
  output logic              valid,
  output logic              noSignal
);

  fmStrobe_t strb;

  fmControl #(
    .TIMEOUT_W (TIMEOUT_W),
    .NSEL_W    (NSEL_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sigIn    (sigIn),
    .nSel     (nSel),
    .strb     (strb),
    .noSignal (noSignal)
  );

  fmDatapath #(
    .CNT_W      (CNT_W),
    .FILT_SHIFT (FILT_SHIFT)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .rawCount  (rawCount),
    .filtCount (filtCount),
    .valid     (valid)
  );

  // R6
  // quiet_valid_chk: no result is published while the input is flagged absent
  quiet_valid_chk: assert property (@(posedge clk) disable iff (rst)
    noSignal |-> !valid);

endmodule

// File: tb/freqMeter_test.sv
module freqMeter_test;

  localparam int TW = 10;
  localparam int NW = 3;
  localparam int KS = 2;
  localparam int CW = TW + (1 << NW);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sigIn = 1'b0;
  logic [NW-1:0] nSel = '0;
  logic [CW-1:0] rawCount, filtCount;
  logic          valid, noSignal;

  freqMeter #(.TIMEOUT_W(TW), .NSEL_W(NW), .FILT_SHIFT(KS)) uut (
    .clk(clk), .rst(rst), .sigIn(sigIn), .nSel(nSel),
    .rawCount(rawCount), .filtCount(filtCount),
    .valid(valid), .noSignal(noSignal)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // input generator: rising edges at phase 0, periods alternate pA / pB
  bit genOn = 0;
  int pA = 20, pB = 20, genHigh = 10;
  int phase = 0;
  bit useB = 0;
  int curPer;

  always @(negedge clk) begin
    cycles = cycles + 1;
    if (!genOn) begin
      sigIn = 1'b0;
      phase = 0;
      useB  = 0;
    end else begin
      curPer = useB ? pB : pA;
      sigIn  = (phase < genHigh);
      if (phase >= curPer - 1) begin
        phase = 0;
        useB  = !useB;
      end else begin
        phase = phase + 1;
      end
    end
  end

  // filter reference model
  bit     mPrimed = 0;
  longint mY = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // wait for the next result; check the filter and strobe behaviour
  task automatic getResult(output longint r, output longint f);
    int guard = 0;
    longint expF;
    @(negedge clk);
    while (!valid) begin
      guard++;
      if (guard > 20000) begin
        chk(0, "R2 result timeout", 0, 1);
        finishRun();
      end
      @(negedge clk);
    end
    r = rawCount;
    f = filtCount;
    if (mPrimed) expF = mY + ((longint'(r) - mY) >>> KS);
    else         expF = r;
    // R5 filter recurrence / first-result load
    chk(f == expF, "R5 filter", f, expF);
    mY = expF;
    mPrimed = 1;
    @(negedge clk);
    // R7 single-cycle strobe with held result
    chk(!valid && rawCount == r, "R7 strobe", valid, 0);
  endtask

  task automatic setWave(input int a, input int b, input int hi);
    pA = a; pB = b; genHigh = hi;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 150000 && !done) begin
        chk(0, "watchdog", cycles, 150000);
        finishRun();
      end
    end
  end

  initial begin
    longint r, f, r2, f2;
    waitCycles(3);
    rst = 1'b0;
    waitCycles(2);
    // R1 reset state
    chk(rawCount == 0 && filtCount == 0, "R1 counts", rawCount, 0);
    chk(!valid && !noSignal, "R1 flags", {valid, noSignal}, 0);

    // R6 at power-up with no input
    waitCycles(1100);
    chk(noSignal == 1, "R6 startup no signal", noSignal, 1);
    mPrimed = 0;

    // R2 sweep of window length and period
    genOn = 1;
    for (int s = 0; s <= 4; s++) begin
      for (int pi = 0; pi < 3; pi++) begin
        int p;
        p = (pi == 0) ? 10 : (pi == 1) ? 25 : 37;
        nSel = NW'(s);
        setWave(p, p, p / 2);
        getResult(r, f);
        getResult(r, f);
        for (int k = 0; k < 3; k++) begin
          getResult(r, f);
          chk(r == (longint'(p) << s), "R2 raw count", r, longint'(p) << s);
        end
      end
    end
    chk(noSignal == 0, "R6 cleared by edges", noSignal, 0);

    // R2 longest window
    nSel = 3'd7;
    setWave(10, 10, 5);
    getResult(r, f);
    getResult(r, f);
    getResult(r, f);
    chk(r == 1280, "R2 raw count N=128", r, 1280);

    // R3 shared boundary: alternating periods
    nSel = 3'd1;
    setWave(20, 21, 10);
    getResult(r, f);
    getResult(r, f);
    for (int k = 0; k < 3; k++) begin
      getResult(r, f);
      chk(r == 41, "R3 two-period window", r, 41);
    end
    nSel = 3'd0;
    getResult(r, f);
    getResult(r, f);
    for (int k = 0; k < 3; k++) begin
      getResult(r, f);
      getResult(r2, f2);
      chk(r + r2 == 41, "R3 consecutive sum", r + r2, 41);
    end

    // R8 duty cycle independence
    nSel = 3'd2;
    setWave(30, 30, 2);
    getResult(r, f);
    getResult(r, f);
    getResult(r, f);
    chk(r == 120, "R8 narrow high", r, 120);
    setWave(30, 30, 28);
    getResult(r, f);
    getResult(r, f);
    chk(r == 120, "R8 wide high", r, 120);

    // R4 nSel change in mid-window
    setWave(20, 20, 10);
    getResult(r, f);
    getResult(r, f);
    waitCycles(30);
    nSel = 3'd1;
    getResult(r, f);
    chk(r == 80, "R4 open window keeps old length", r, 80);
    getResult(r, f);
    chk(r == 40, "R4 new length next window", r, 40);

    // R6 stall in mid-window
    nSel = 3'd5;
    setWave(50, 50, 25);
    getResult(r, f);
    getResult(r, f);
    waitCycles(200);
    genOn = 0;
    begin
      int seen = 0;
      for (int i = 0; i < 800; i++) begin
        @(negedge clk);
        if (valid) seen++;
      end
      chk(noSignal == 0, "R6 not yet timed out", noSignal, 0);
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (valid) seen++;
      end
      chk(noSignal == 1, "R6 timed out", noSignal, 1);
      chk(seen == 0, "R6 dropped window", seen, 0);
    end
    mPrimed = 0;

    // R6 restart and R5 reload after no-signal
    nSel = 3'd0;
    setWave(40, 40, 20);
    genOn = 1;
    getResult(r, f);
    chk(r == 40, "R6 fresh window", r, 40);
    chk(f == r, "R5 reload after no-signal", f, r);
    chk(noSignal == 0, "R6 cleared", noSignal, 0);

    done = 1;
    finishRun();
  end

endmodule